// File: doc/BRIEF.md
# Bus Address Decoder with Wait States

This block sits between a 32-bit processor's load/store port and a set of memory-mapped slaves. It accepts one access at a time, made up of an address, a size (byte, halfword or word) and a direction flag. It compares the address against a table of up to eight programmable regions. It then raises a one-hot select for the region that wins, hands the slave the offset inside that region, and counts that region's wait cycles for the chosen direction before it acknowledges.

Each region is loaded through a configuration port that takes a base address and a size. The block rounds the size up to a power of two and forms the match mask from it. One region can carry a priority flag, for a memory controller. That region is tested before all others and is chosen even when its valid bit is clear. The remaining regions must be valid, and among them the lowest index wins. A misaligned access is answered with an alignment error. An access that maps nowhere, or that reaches a region closed to that direction, is answered with a bus error. In both cases no select is raised.

Top module: `bus_region_decoder`

## Requirements
- R1: Writing a region with base B and size S sets its span to S rounded up to the next power of two, and aligns its base by clearing the low bits of B below that span. An address hits the region when it falls inside that aligned span. A size of 0 spans the whole address space.
- R2: While an access to a region is in progress, `sel` has exactly that region's bit set. `offset` equals the address ANDed with (span−1).
- R3: A region holding the priority flag is tested first and wins over any other region it overlaps, whether or not its valid bit is set.
- R4: Apart from the priority region, a region takes part in matching only while its valid bit is set. Among the valid regions that match, the lowest index wins.
- R5: `req_size` is encoded 0 = byte, 1 = halfword, 2 = word, and 3 is treated as a word. A word access with either of its two low address bits set, or a halfword access with bit 0 set, raises `err_align` for one cycle, starting at the accepting edge. A byte access never raises it.
- R6: An aligned access that hits no region raises `err_bus` for one cycle, starting at the accepting edge, and `sel` stays zero.
- R7: The read and write delays are signed. When the winning region's delay for the access direction is negative, the access gets `err_bus` instead of a select.
- R8: For a hit with delay d, `ack` is high for exactly one cycle: the cycle that begins at the d-th rising edge after the accepting edge. With d = 0 it begins at the accepting edge itself.
- R9: `req_ready` is low from the accepting edge until the response cycle ends. A request presented while it is low has no effect.
- R10: Writing a region with the priority flag set removes the flag from every other region.
- R11: After reset every region is invalid and none holds the priority flag, so every aligned access gets `err_bus`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write one region entry |
| cfg_idx | input | 3 | Region index being written |
| cfg_base | input | 32 | Region base address |
| cfg_size | input | 32 | Region size in bytes (0 = whole space) |
| cfg_rd_dly | input | 6 | Signed read delay; negative forbids reads |
| cfg_wr_dly | input | 6 | Signed write delay; negative forbids writes |
| cfg_valid | input | 1 | Region valid bit |
| cfg_mc | input | 1 | Priority (memory controller) flag |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Decoder idle, request will be taken |
| req_addr | input | 32 | Access address |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_write | input | 1 | 1 = write, 0 = read |
| sel | output | 8 | One-hot region select |
| offset | output | 32 | Offset inside the selected region |
| ack | output | 1 | Access completed |
| err_align | output | 1 | Misaligned access response |
| err_bus | output | 1 | Unmapped or forbidden access response |

## Verification
The response timing is counted in falling edges after the rising edge that accepts a request. An error response must already be visible at the first falling edge (count 0). An acknowledge with delay d must first appear at count d, with `sel` and `offset` valid at that point. The bench drives every request on a falling edge and releases it at the next one. It then counts falling edges until a response appears and compares that count with the delay it programmed. One falling edge later it confirms that `req_ready` has returned and that the response has dropped, which shows that each response lasts exactly one cycle.

// File: rtl/bus_region_decoder.sv
module bus_region_decoder #(
  parameter int AW   = 32,
  parameter int NREG = 8,
  parameter int DW   = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [2:0]           cfg_idx,
  input  logic [AW-1:0]        cfg_base,
  input  logic [AW-1:0]        cfg_size,
  input  logic [DW-1:0]        cfg_rd_dly,
  input  logic [DW-1:0]        cfg_wr_dly,
  input  logic                 cfg_valid,
  input  logic                 cfg_mc,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [AW-1:0]        req_addr,
  input  logic [1:0]           req_size,
  input  logic                 req_write,
  output logic [NREG-1:0]      sel,
  output logic [AW-1:0]        offset,
  output logic                 ack,
  output logic                 err_align,
  output logic                 err_bus
);
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;
  localparam int CW = DW - 1;

  logic [AW-1:0] r_mask [NREG];
  logic [AW-1:0] r_cmp  [NREG];
  logic [DW-1:0] r_rd   [NREG];
  logic [DW-1:0] r_wr   [NREG];
  logic [NREG-1:0] r_val, r_mc;

  function automatic logic [AW-1:0] span_of(input logic [AW-1:0] sz);
    logic [AW-1:0] m;
    m = sz - 1'b1;
    for (int i = 1; i < AW; i++) m = m | (m >> i);
    return m;
  endfunction

  logic [AW-1:0] cfg_span;
  logic [NREG-1:0] cfg_bit;
  assign cfg_span = span_of(cfg_size);
  assign cfg_bit  = NREG'(1) << cfg_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_val <= '0;
      r_mc  <= '0;
      for (int i = 0; i < NREG; i++) begin
        r_mask[i] <= '0;
        r_cmp[i]  <= '0;
        r_rd[i]   <= '0;
        r_wr[i]   <= '0;
      end
    end else if (cfg_we && (int'(cfg_idx) < NREG)) begin
      r_mask[IW'(cfg_idx)] <= ~cfg_span;
      r_cmp[IW'(cfg_idx)]  <= cfg_base & ~cfg_span;
      r_rd[IW'(cfg_idx)]   <= cfg_rd_dly;
      r_wr[IW'(cfg_idx)]   <= cfg_wr_dly;
      r_val[IW'(cfg_idx)]  <= cfg_valid;
      r_mc <= cfg_mc ? cfg_bit : (r_mc & ~cfg_bit);
    end
  end

  logic [NREG-1:0] hit;
  for (genvar g = 0; g < NREG; g++) begin : g_match
    assign hit[g] = (req_addr & r_mask[g]) == r_cmp[g];
  end

  logic [NREG-1:0] mc_hit, gen_hit, pick;
  assign mc_hit  = hit & r_mc;
  assign gen_hit = hit & r_val;
  assign pick    = (|mc_hit) ? mc_hit : (gen_hit & (~gen_hit + 1'b1));

  logic [IW-1:0] win;
  always_comb begin
    win = '0;
    for (int i = 0; i < NREG; i++)
      if (pick[i]) win = IW'(i);
  end

  logic misal, forbid;
  logic [DW-1:0] dly;
  assign misal  = (req_size == 2'd1 && req_addr[0]) || (req_size[1] && (|req_addr[1:0]));
  assign dly    = req_write ? r_wr[win] : r_rd[win];
  assign forbid = dly[DW-1];

  logic busy, is_err, is_align;
  logic [CW-1:0] cnt;
  logic [NREG-1:0] sel_q;
  logic [AW-1:0] off_q;

  assign req_ready = ~busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; is_err <= 1'b0; is_align <= 1'b0;
      cnt <= '0; sel_q <= '0; off_q <= '0;
    end else if (!busy) begin
      if (req_valid) begin
        busy <= 1'b1;
        if (misal) begin
          is_err <= 1'b1; is_align <= 1'b1; cnt <= '0;
        end else if (pick == '0 || forbid) begin
          is_err <= 1'b1; is_align <= 1'b0; cnt <= '0;
        end else begin
          sel_q <= pick;
          off_q <= req_addr & ~r_mask[win];
          cnt   <= dly[CW-1:0];
        end
      end
    end else if (cnt == '0) begin
      busy <= 1'b0; is_err <= 1'b0; is_align <= 1'b0;
      sel_q <= '0; off_q <= '0;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  assign sel       = sel_q;
  assign offset    = off_q;
  assign ack       = busy & ~is_err & (cnt == '0);
  assign err_align = busy & is_err & is_align;
  assign err_bus   = busy & is_err & ~is_align;
endmodule

module bus_region_decoder_chk #(
  parameter int AW   = 32,
  parameter int NREG = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [AW-1:0]   req_addr,
  input logic [1:0]      req_size,
  input logic [NREG-1:0] sel,
  input logic            ack,
  input logic            err_align,
  input logic            err_bus
);
  // R5
  word_misalign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_size[1] && req_addr[1:0] != 2'b00) |=> err_align);
  // R5
  byte_never_misaligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_size == 2'd0) |=> !err_align);
  // R6
  err_without_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_align || err_bus) |-> sel == '0);
  // R2
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));
  // R8
  ack_has_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $countones(sel) == 1);
  // R9
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R8
  single_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ack, err_align, err_bus}) <= 1);
endmodule

bind bus_region_decoder bus_region_decoder_chk #(.AW(AW), .NREG(NREG)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_size(req_size), .sel(sel), .ack(ack),
  .err_align(err_align), .err_bus(err_bus));

// File: tb/bus_region_decoder_tb.sv
module bus_region_decoder_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_valid = 0, cfg_mc = 0;
  logic [2:0] cfg_idx = 0;
  logic [31:0] cfg_base = 0, cfg_size = 0;
  logic [5:0] cfg_rd_dly = 0, cfg_wr_dly = 0;
  logic req_valid = 0, req_write = 0;
  logic [31:0] req_addr = 0;
  logic [1:0] req_size = 0;
  logic req_ready, ack, err_align, err_bus;
  logic [7:0] sel;
  logic [31:0] offset;

  int vectors = 0, misses = 0;
  bit done = 0;

  localparam int K_ACK = 0, K_ALIGN = 1, K_BUS = 2;

  always #5 clk = ~clk;

  bus_region_decoder dut_i (.*);

  task automatic check(bit ok, string rq, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic cfg(int idx, logic [31:0] base, logic [31:0] size, int rd, int wr, bit v, bit mc);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 3'(idx); cfg_base = base; cfg_size = size;
    cfg_rd_dly = 6'(rd); cfg_wr_dly = 6'(wr); cfg_valid = v; cfg_mc = mc;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic access(string rq, logic [31:0] addr, logic [1:0] sz, bit wr,
                        int kind, int dly, logic [7:0] esel, logic [31:0] eoff);
    int n = 0;
    @(negedge clk);
    check(req_ready, rq, "ready before request", 32'(req_ready), 1);
    req_valid = 1; req_addr = addr; req_size = sz; req_write = wr;
    @(negedge clk);
    req_valid = 0;
    while (!(ack || err_align || err_bus) && n < 64) begin
      @(negedge clk); n++;
    end
    if (kind == K_ACK) begin
      check(ack && n == dly, rq, "ack cycle", 32'(n), 32'(dly));
      check(sel == esel, rq, "sel", 32'(sel), 32'(esel));
      check(offset == eoff, rq, "offset", offset, eoff);
    end else begin
      check(n == 0, rq, "error cycle", 32'(n), 0);
      check(kind == K_ALIGN ? err_align : err_bus, rq, "error kind",
            {30'd0, err_bus, err_align}, kind == K_ALIGN ? 1 : 2);
      check(sel == 0, rq, "sel on error", 32'(sel), 0);
    end
    @(negedge clk);
    check(req_ready && !ack && !err_align && !err_bus, rq, "idle after response",
          {28'd0, req_ready, ack, err_align, err_bus}, 32'h8);
  endtask

  task automatic t_reset();
    check(req_ready && sel == 0 && !ack && !err_bus && !err_align, "R11", "reset outputs",
          {23'd0, sel, req_ready}, 1);
    access("R11", 32'h100, 2, 0, K_BUS, 0, 0, 0);
    access("R6", 32'hFFFF_FFF0, 1, 1, K_BUS, 0, 0, 0);
  endtask

  task automatic t_basic();
    cfg(1, 32'h1000, 32'h300, 2, 3, 1, 0);
    access("R1", 32'h13FC, 2, 0, K_ACK, 2, 8'h02, 32'h3FC);
    access("R8", 32'h1002, 1, 1, K_ACK, 3, 8'h02, 32'h2);
    access("R1", 32'h1400, 2, 0, K_BUS, 0, 0, 0);
    access("R5", 32'h1001, 0, 0, K_ACK, 2, 8'h02, 32'h1);
    cfg(2, 32'h2345, 32'h100, 0, 0, 1, 0);
    access("R2", 32'h2300, 2, 0, K_ACK, 0, 8'h04, 32'h0);
    access("R2", 32'h23F7, 0, 1, K_ACK, 0, 8'h04, 32'hF7);
  endtask

  task automatic t_align();
    access("R5", 32'h1002, 2, 0, K_ALIGN, 0, 0, 0);
    access("R5", 32'h1001, 1, 1, K_ALIGN, 0, 0, 0);
    access("R5", 32'h1002, 3, 0, K_ALIGN, 0, 0, 0);
    access("R5", 32'h1001, 2, 0, K_ALIGN, 0, 0, 0);
  endtask

  task automatic t_priority();
    cfg(3, 32'h1000, 32'h10, 0, 0, 1, 0);
    access("R4", 32'h1004, 2, 0, K_ACK, 2, 8'h02, 32'h4);
    cfg(1, 32'h1000, 32'h300, 2, 3, 0, 0);
    access("R4", 32'h1004, 2, 0, K_ACK, 0, 8'h08, 32'h4);
    access("R4", 32'h1100, 2, 0, K_BUS, 0, 0, 0);
  endtask

  task automatic t_forbid();
    cfg(4, 32'h8000, 32'h100, 1, -1, 1, 0);
    access("R7", 32'h8010, 2, 0, K_ACK, 1, 8'h10, 32'h10);
    access("R7", 32'h8010, 2, 1, K_BUS, 0, 0, 0);
  endtask

  task automatic t_mc();
    cfg(6, 32'h1000, 32'h1000, 4, 4, 0, 1);
    access("R3", 32'h1004, 2, 0, K_ACK, 4, 8'h40, 32'h4);
    access("R3", 32'h1FF0, 1, 1, K_ACK, 4, 8'h40, 32'hFF0);
    access("R6", 32'h9000, 2, 0, K_BUS, 0, 0, 0);
    cfg(5, 32'h1000, 32'h10, 1, 1, 1, 1);
    access("R10", 32'h1004, 2, 0, K_ACK, 1, 8'h20, 32'h4);
    access("R10", 32'h1800, 2, 0, K_BUS, 0, 0, 0);
  endtask

  task automatic t_busy();
    int n = 0;
    cfg(7, 32'hA000, 32'h10, 3, 3, 1, 0);
    @(negedge clk);
    req_valid = 1; req_addr = 32'hA008; req_size = 2; req_write = 0;
    @(negedge clk);
    req_addr = 32'hA001; req_size = 2;
    check(!req_ready, "R9", "ready while waiting", 32'(req_ready), 0);
    @(negedge clk);
    req_valid = 0;
    n = 1;
    while (!(ack || err_align || err_bus) && n < 64) begin
      @(negedge clk); n++;
    end
    check(ack && n == 3 && offset == 32'h8 && sel == 8'h80, "R9", "first access kept",
          {offset[15:0], 8'(n), sel}, {16'h8, 8'd3, 8'h80});
    @(negedge clk);
    check(req_ready && !ack && !err_align && !err_bus, "R9", "ignored request left no trace",
          {28'd0, req_ready, ack, err_align, err_bus}, 32'h8);
  endtask

  task automatic t_whole();
    cfg(0, 32'h0, 32'h0, 0, 0, 1, 0);
    access("R1", 32'h9000, 2, 0, K_ACK, 0, 8'h01, 32'h9000);
    access("R1", 32'hFFFF_FFFC, 2, 1, K_ACK, 0, 8'h01, 32'hFFFF_FFFC);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_basic();
    t_align();
    t_priority();
    t_forbid();
    t_mc();
    t_busy();
    t_whole();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      vectors++; misses++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule